// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The controller manages 85 general-purpose pins arranged as three banks of up to 32 pins. Each pin has an output latch, a direction bit and a level readback. Each pin also has independent rising and falling edge detect enables and a sticky edge-status bit. A 2-bit function selector per pin is passed to the pin multiplexing outside the block. Software reaches all of this through a single-cycle 32-bit write port and a registered read port, using word addresses.

Pin inputs are resynchronised to the clock before level readback and edge detection. Enabled edges latch into the status bits, and the status bits feed three interrupt lines. Pin 0 and pin 1 each have a line of their own. Every other pin shares the third line.

Top module: `gpio_ctrl`

## Requirements
- R1: After synchronous reset, every direction, latch, enable, status and function bit is 0. `pin_out`, `pin_oe`, `pin_func` and all three interrupt outputs are 0.
- R2: Bank 2 holds pins 64..84 in bits 0..20 only. Its bits 21..31 always read as 0 and writes to them have no effect. A direction bit of 1 makes its pin an output (`pin_oe` high).
- R3: A write to a set port ORs the written 1 bits into the output latch. A write to a clear port removes the written 1 bits from it. Bits written as 0 leave the latch unchanged. Both ports read as 0.
- R4: The level register of a bank returns the synchronised state of every pin in that bank, whatever its direction.
- R5: No edge is recorded while both enables of a pin are 0, which is the state after reset. A rising edge is not recorded when only the falling enable is set.
- R6: A 0-to-1 change on a pin with its rising enable set, or a 1-to-0 change with its falling enable set, sets that pin's status bit.
- R7: Status bits stay set until a 1 is written to them at the status address. Writing 0 has no effect.
- R8: Status bit 0 drives `irq_pin0`, status bit 1 drives `irq_pin1`, and any set status bit of pins 2..84 drives `irq_shared`.
- R9: If a clear write to a status bit and a new enabled edge on that pin fall in the same cycle, the bit stays set.
- R10: Each interrupt output rises exactly one clock after its status bit is set. A pin change applied between two clock edges reaches the status bit at the third following edge, because of a two-flop synchroniser plus one compare stage.
- R11: Function registers pack 16 pins each, with pin n at bits 2*(n%16)+1 : 2*(n%16) of register n/16. The last register implements only bits 0..9. Values appear on `pin_func[2n+1:2n]`.
- R12: The word address is group*4 + bank. The groups are level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5 and status 6. Function register k sits at word address 32 + k. `bus_rdata` holds the data for the address presented one clock earlier, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the address |
| pin_in | input | 85 | Raw pin levels |
| pin_out | output | 85 | Output latch |
| pin_oe | output | 85 | Output enable (direction) |
| pin_func | output | 170 | 2-bit function selector per pin |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt shared by pins 2..84 |

## Verification
The assertions assume that `rst` is high at time zero and through the first edge. They also assume that a pin change lasts at least two clocks, so the synchroniser cannot miss it and a status rise can always be traced to the enables of the previous cycle. The stimulus changes pins and bus fields only on the falling clock edge and holds every pin level for at least four clocks. It drives the collision case by timing the clear write to the exact cycle in which the edge compare fires.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register group, taken from the upper bits of the word address
    typedef enum logic [3:0] {
        GRP_LEVEL   = 4'd0,
        GRP_DIR     = 4'd1,
        GRP_SET     = 4'd2,
        GRP_CLR     = 4'd3,
        GRP_RISE    = 4'd4,
        GRP_FALL    = 4'd5,
        GRP_STAT    = 4'd6,
        GRP_FUNC_LO = 4'd8,
        GRP_FUNC_HI = 4'd9
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e   grp;
        logic [1:0] bank;
    } reg_addr_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int slice_width(input int total, input int lo, input int w);
        return (total - lo < w) ? (total - lo) : w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 85
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl    <= '0;
            lvl_d  <= '0;
        end else begin
            meta_q <= pin_in;
            lvl    <= meta_q;
            lvl_d  <= lvl;
        end
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int W = 85
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_d,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] hit;

    // A new edge takes priority over a clear in the same cycle
    assign hit = (rise_en & lvl & ~lvl_d) | (fall_en & ~lvl & lvl_d);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | hit;
    end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int W = 85
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] status,
    output logic         irq_pin0,
    output logic         irq_pin1,
    output logic         irq_shared
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pin0   <= 1'b0;
            irq_pin1   <= 1'b0;
            irq_shared <= 1'b0;
        end else begin
            irq_pin0   <= status[0];
            irq_pin1   <= status[1];
            irq_shared <= |status[W-1:2];
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
    parameter int NUM_PINS = 85,
    parameter int BANK_W   = 32,
    parameter int FN_W     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [5:0]               bus_addr,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    input  logic [NUM_PINS-1:0]      pin_in,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic [NUM_PINS*FN_W-1:0] pin_func,
    output logic                     irq_pin0,
    output logic                     irq_pin1,
    output logic                     irq_shared
);
    import gpio_pkg::*;

    localparam int NB     = ceil_div(NUM_PINS, BANK_W);
    localparam int FN_TOT = NUM_PINS * FN_W;
    localparam int NF     = ceil_div(FN_TOT, BANK_W);

    reg_addr_t ra;
    logic      is_func;
    logic [2:0] fidx;

    assign ra      = bus_addr;
    assign is_func = (ra.grp == GRP_FUNC_LO) || (ra.grp == GRP_FUNC_HI);
    assign fidx    = {ra.grp == GRP_FUNC_HI, ra.bank};

    logic [NUM_PINS-1:0] dir_q, latch_q, rise_q, fall_q;
    logic [NUM_PINS-1:0] lvl, lvl_d, status_q, clr_mask;
    logic [FN_TOT-1:0]   func_q;

    logic [NB-1:0][BANK_W-1:0] bank_rd;
    logic [NF-1:0][BANK_W-1:0] fn_rd;
    logic [BANK_W-1:0]         rd_next;

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .lvl(lvl), .lvl_d(lvl_d)
    );

    gpio_edge_status #(.W(NUM_PINS)) u_edge (
        .clk(clk), .rst(rst), .lvl(lvl), .lvl_d(lvl_d),
        .rise_en(rise_q), .fall_en(fall_q), .clr_mask(clr_mask),
        .status(status_q)
    );

    gpio_irq_route #(.W(NUM_PINS)) u_irq (
        .clk(clk), .rst(rst), .status(status_q),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
    );

    // Per-bank pin registers; the last bank may be narrower than the bus
    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        localparam int BW = slice_width(NUM_PINS, LO, BANK_W);

        logic          hit;
        logic [BW-1:0] wd;
        logic [BANK_W-1:0] rd_b;

        assign hit = bus_we && !is_func && (ra.bank == 2'(b));
        assign wd  = bus_wdata[BW-1:0];

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[LO+:BW]   <= '0;
                latch_q[LO+:BW] <= '0;
                rise_q[LO+:BW]  <= '0;
                fall_q[LO+:BW]  <= '0;
            end else if (hit) begin
                case (ra.grp)
                    GRP_DIR:  dir_q[LO+:BW]   <= wd;
                    GRP_SET:  latch_q[LO+:BW] <= latch_q[LO+:BW] | wd;
                    GRP_CLR:  latch_q[LO+:BW] <= latch_q[LO+:BW] & ~wd;
                    GRP_RISE: rise_q[LO+:BW]  <= wd;
                    GRP_FALL: fall_q[LO+:BW]  <= wd;
                    default:  ;
                endcase
            end
        end

        assign clr_mask[LO+:BW] = (hit && ra.grp == GRP_STAT) ? wd : '0;

        always_comb begin
            rd_b = '0;
            case (ra.grp)
                GRP_LEVEL: rd_b[BW-1:0] = lvl[LO+:BW];
                GRP_DIR:   rd_b[BW-1:0] = dir_q[LO+:BW];
                GRP_RISE:  rd_b[BW-1:0] = rise_q[LO+:BW];
                GRP_FALL:  rd_b[BW-1:0] = fall_q[LO+:BW];
                GRP_STAT:  rd_b[BW-1:0] = status_q[LO+:BW];
                default:   rd_b = '0;
            endcase
        end

        assign bank_rd[b] = rd_b;
    end

    // Function selector registers, FN_W bits per pin
    for (genvar f = 0; f < NF; f++) begin : g_func
        localparam int FLO = f * BANK_W;
        localparam int FBW = slice_width(FN_TOT, FLO, BANK_W);

        logic [BANK_W-1:0] rd_f;

        always_ff @(posedge clk) begin
            if (rst)
                func_q[FLO+:FBW] <= '0;
            else if (bus_we && is_func && fidx == 3'(f))
                func_q[FLO+:FBW] <= bus_wdata[FBW-1:0];
        end

        always_comb begin
            rd_f = '0;
            rd_f[FBW-1:0] = func_q[FLO+:FBW];
        end

        assign fn_rd[f] = rd_f;
    end

    always_comb begin
        rd_next = '0;
        if (is_func) begin
            for (int f = 0; f < NF; f++)
                if (fidx == 3'(f)) rd_next = fn_rd[f];
        end else begin
            for (int b = 0; b < NB; b++)
                if (ra.bank == 2'(b)) rd_next = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

    assign pin_out  = latch_q;
    assign pin_oe   = dir_q;
    assign pin_func = func_q;

endmodule

// File: rtl/gpio_ctrl_check.sv
module gpio_ctrl_check #(
    parameter int NUM_PINS = 85
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [5:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] clr_mask,
    input logic [NUM_PINS-1:0] rise_q,
    input logic [NUM_PINS-1:0] fall_q,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq_pin0,
    input logic                irq_pin1,
    input logic                irq_shared
);
    localparam int NB    = (NUM_PINS + 31) / 32;
    localparam int LASTW = NUM_PINS - (NB - 1) * 32;
    localparam logic [31:0] LAST_MASK =
        (LASTW >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << LASTW) - 64'd1);

    // R7: a set status bit only drops when a clear of that bit was written
    assert_sticky_status_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

    // R5 / R6: a status bit can only rise if one of its enables was set
    assert_edge_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~($past(rise_q) | $past(fall_q))) == '0));

    // R8 / R10: interrupt lines follow their status bits one clock later
    assert_irq0_route_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pin0) |-> $past(status_q[0]));
    assert_irq1_route_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pin1) |-> $past(status_q[1]));
    assert_irq_shared_route_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_shared) |-> $past(|status_q[NUM_PINS-1:2]));
    assert_irq0_drop_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_pin0) |-> !$past(status_q[0]));

    // R2: unimplemented bits of the last bank read as zero
    assert_last_bank_mask_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_addr[1:0]) == 2'(NB - 1) && $past(bus_addr[5:2]) <= 4'd6)
        |-> ((bus_rdata & ~LAST_MASK) == 32'd0));

    // R2: direction only changes after a direction write
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we && bus_addr[5:2] == 4'd1) |-> $stable(pin_oe));

endmodule

bind gpio_ctrl gpio_ctrl_check #(.NUM_PINS(NUM_PINS)) u_check (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .status_q(status_q), .clr_mask(clr_mask),
    .rise_q(rise_q), .fall_q(fall_q), .pin_oe(pin_oe),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
);

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ctrl_test;
    localparam int NP = 85;
    localparam int G_LEVEL = 0, G_DIR = 1, G_SET = 2, G_CLR = 3;
    localparam int G_RISE = 4, G_FALL = 5, G_STAT = 6, G_FN = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [2*NP-1:0] pin_func;
    logic          irq_pin0, irq_pin1, irq_shared;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 6'(a);
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic irq_chk(input string req, input int p, input bit on);
        chk(req, {29'd0, irq_pin0, irq_pin1, irq_shared},
            {29'd0, on && p == 0, on && p == 1, on && p >= 2});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NP-1:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int b = 0; b < 3; b++) begin
            rd(G_RISE*4 + b, v); chk("R1 rise", v, 0);
            rd(G_FALL*4 + b, v); chk("R1 fall", v, 0);
            rd(G_STAT*4 + b, v); chk("R1 status", v, 0);
            rd(G_DIR*4 + b, v);  chk("R1 dir", v, 0);
        end
        chk("R1 outputs", {31'd0, (|pin_out) | (|pin_oe) | (|pin_func)}, 0);
        irq_chk("R1 irq", 0, 1'b0);

        // R2: direction and bank-2 width
        wr(G_DIR*4 + 2, 32'hFFFF_FFFF);
        rd(G_DIR*4 + 2, v); chk("R2 bank2 dir readback", v, 32'h001F_FFFF);
        chk("R2 bank2 oe", {11'd0, pin_oe[84:64]}, 32'h001F_FFFF);
        wr(G_DIR*4 + 0, 32'h0000_0005);
        rd(G_DIR*4 + 0, v); chk("R2 bank0 dir", v, 32'h5);
        chk("R2 bank0 oe", pin_oe[31:0], 32'h5);

        // R3: set and clear ports
        wr(G_SET*4 + 1, 32'hF0F0_F0F0);
        chk("R3 set", pin_out[63:32], 32'hF0F0_F0F0);
        wr(G_CLR*4 + 1, 32'h3000_0001);
        chk("R3 clear", pin_out[63:32], 32'hC0F0_F0F0);
        wr(G_SET*4 + 1, 32'h0000_0000);
        chk("R3 zero set", pin_out[63:32], 32'hC0F0_F0F0);
        wr(G_SET*4 + 2, 32'hFFFF_FFFF);
        chk("R3 set bank2", {11'd0, pin_out[84:64]}, 32'h001F_FFFF);
        wr(G_CLR*4 + 2, 32'hFFFF_FFFF);
        chk("R3 clear bank2", {11'd0, pin_out[84:64]}, 0);
        rd(G_SET*4 + 1, v); chk("R3 set reads 0", v, 0);
        rd(G_CLR*4 + 1, v); chk("R3 clear reads 0", v, 0);

        // R4: level readback regardless of direction; R5 no enables -> no status
        pat = {21'h15A5A5, 32'h1234_5678, 32'hDEAD_BEEF};
        @(negedge clk); pin_in = pat;
        wait_cyc(4);
        for (int b = 0; b < 3; b++) begin
            rd(G_LEVEL*4 + b, v);
            chk("R4 level", v, (b == 2) ? {11'd0, pat[84:64]} : pat[b*32 +: 32]);
        end
        @(negedge clk); pin_in = '0;
        wait_cyc(4);
        for (int b = 0; b < 3; b++) begin
            rd(G_STAT*4 + b, v); chk("R5 no enable no status", v, 0);
        end
        irq_chk("R5 irq quiet", 0, 1'b0);

        // R6 / R7 / R8 / R5: sweep every pin through both edges
        for (int p = 0; p < NP; p++) begin
            int b;
            logic [31:0] m;
            b = p / 32;
            m = 32'd1 << (p % 32);
            wr(G_RISE*4 + b, m);
            @(negedge clk); pin_in[p] = 1'b1;
            wait_cyc(4);
            rd(G_STAT*4 + b, v); chk("R6 rise sets status", v, m);
            irq_chk("R8 irq route rise", p, 1'b1);
            wr(G_STAT*4 + b, 32'd0);
            rd(G_STAT*4 + b, v); chk("R7 write 0 keeps status", v, m);
            wr(G_STAT*4 + b, m);
            rd(G_STAT*4 + b, v); chk("R7 write 1 clears", v, 0);
            irq_chk("R8 irq drop", p, 1'b0);
            wr(G_RISE*4 + b, 32'd0);
            wr(G_FALL*4 + b, m);
            @(negedge clk); pin_in[p] = 1'b0;
            wait_cyc(4);
            rd(G_STAT*4 + b, v); chk("R6 fall sets status", v, m);
            irq_chk("R8 irq route fall", p, 1'b1);
            wr(G_STAT*4 + b, m);
            @(negedge clk); pin_in[p] = 1'b1;
            wait_cyc(4);
            rd(G_STAT*4 + b, v); chk("R5 rise ignored with fall enable", v, 0);
            wr(G_FALL*4 + b, 32'd0);
            @(negedge clk); pin_in[p] = 1'b0;
            wait_cyc(4);
        end

        // R9: clear write coinciding with a new edge
        wr(G_RISE*4, 32'h20);
        wr(G_FALL*4, 32'h20);
        @(negedge clk); pin_in[5] = 1'b1;
        wait_cyc(4);
        rd(G_STAT*4, v); chk("R9 setup", v, 32'h20);
        @(negedge clk); pin_in[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(G_STAT*4); bus_wdata = 32'h20;
        @(negedge clk);
        bus_we = 1'b0;
        rd(G_STAT*4, v); chk("R9 edge wins over clear", v, 32'h20);
        wr(G_STAT*4, 32'h20);
        rd(G_STAT*4, v); chk("R9 later clear works", v, 0);
        wr(G_RISE*4, 32'h0);
        wr(G_FALL*4, 32'h0);

        // R10: latency from pin change to status and interrupt
        wr(G_RISE*4, 32'h1);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 no irq after two edges", {31'd0, irq_pin0}, 0);
        @(negedge clk);
        chk("R10 irq low when status sets", {31'd0, irq_pin0}, 0);
        @(negedge clk);
        chk("R10 irq one clock later", {31'd0, irq_pin0}, 1);
        wr(G_STAT*4, 32'h1);
        wr(G_RISE*4, 32'h0);
        @(negedge clk); pin_in[0] = 1'b0;
        wait_cyc(4);

        // R11 / R12: function registers
        wr(G_FN + 5, 32'hFFFF_FFFF);
        rd(G_FN + 5, v); chk("R11 last fn reg mask", v, 32'h0000_03FF);
        chk("R11 last fn pins", {22'd0, pin_func[169:160]}, 32'h3FF);
        wr(G_FN + 2, 32'h0000_0009);
        rd(G_FN + 2, v); chk("R11 fn readback", v, 32'h9);
        chk("R11 pin32 field", {30'd0, pin_func[65:64]}, 32'd1);
        chk("R11 pin33 field", {30'd0, pin_func[67:66]}, 32'd2);
        rd(7*4, v); chk("R12 unmapped reads 0", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule